// File: doc/BRIEF.md
# Mode-Selectable Twisted-Ring Sequencer

A four-stage shift register that steps through one of four fixed state cycles on every clock edge. The cycle is set by a 2-bit mode input. One mode circulates a single set bit around the register. The other three feed an inverted or gated tap back into the tail, giving twisted-ring cycles of length 2n, 2n-1 or 2n-2 for an n-bit register. The odd and even variants derive their tail bit from the two stages at the head of the register, QA and QB. This lets them skip the all-zero state, or both the all-zero and all-one states.

Every cycle starts from the seed pattern 0001. A valid flag reports whether the held state belongs to the cycle of the current mode. A one-hot decode names the position of that state within the cycle. If the held state is foreign to the current mode, for example after a mode switch, the register falls back to the seed on the next edge. The width is a parameter; the requirements below use the default of four stages.

Top module: `seq_twisted_ring`

## Requirements
- R1: While clr_ni is low at a rising clock edge, state_o becomes 0001 after that edge, whatever the mode and the prior state.
- R2: State bits are written QA..QD with QA = state_o[3] and QD = state_o[0]. On a legal, uncleared edge, QD moves into QC, QC into QB and QB into QA, and QD receives the mode's tail bit.
- R3: Mode 0 (ring) has the tail bit QA. From 0001 it cycles 0001, 0010, 0100, 1000 with positions 0..3.
- R4: Mode 1 (full twist) has the tail bit NOT QA. It cycles 0001, 0011, 0111, 1111, 1110, 1100, 1000, 0000 with positions 0..7.
- R5: Mode 2 (odd) has the tail bit NOT(QA AND QB). It cycles 0001, 0011, 0111, 1111, 1110, 1100, 1000 with positions 0..6, and 0000 is never entered.
- R6: Mode 3 (even) has the tail bit NOT QB. It cycles 0001, 0011, 0111, 1110, 1100, 1000 with positions 0..5, and neither 1111 nor 0000 is entered.
- R7: A state outside the current mode's cycle drives valid_o low during that cycle, and state_o is 0001 after the next edge.
- R8: onehot_o bit k is high only when valid_o is high and the state sits at position k of the current mode's cycle. No bit is high when the state is illegal.
- R9: A mode change acts at the next edge. A state that is legal in the new mode is kept and advanced with the new mode's tail bit.
- R10: rst_ni low forces state_o to 0001 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Synchronous clear to the seed, active low |
| mode_i | input | 2 | Cycle select: 0 ring, 1 full, 2 odd, 3 even |
| state_o | output | 4 | Register contents, QA in bit 3 and QD in bit 0 |
| onehot_o | output | 8 | Position of the state within the current cycle |
| valid_o | output | 1 | State belongs to the current cycle |

## Verification
Each mode is run for one full lap from the seed, so that its cycle length and its wrap back to 0001 are both observed. The laps are chained back to back, so each mode switch lands on a state that is legal in the next mode and shows that the state is kept. Illegal entries are set up on purpose: 1111 under the even mode, 0011 under the ring mode and 0000 under the odd mode. These separate the recovery path from the normal tail feedback. A clear in the middle of a lap and an asynchronous reset between edges complete the stimulus.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    MODE_RING = 2'd0,
    MODE_FULL = 2'd1,
    MODE_ODD  = 2'd2,
    MODE_EVEN = 2'd3
  } seq_mode_e;

  // tail bit from the two head taps
  function automatic logic seq_tail(seq_mode_e m, logic qa, logic qb);
    logic t;
    case (m)
      MODE_RING: t = qa;
      MODE_FULL: t = ~qa;
      MODE_ODD:  t = ~(qa & qb);
      default:   t = ~qb;
    endcase
    return t;
  endfunction

  function automatic int unsigned seq_len(seq_mode_e m, int unsigned w);
    int unsigned l;
    case (m)
      MODE_RING: l = w;
      MODE_FULL: l = 2 * w;
      MODE_ODD:  l = 2 * w - 1;
      default:   l = 2 * w - 2;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/seq_feedback.sv
module seq_feedback import seq_pkg::*; #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] state_i,
  input  seq_mode_e        mode_i,
  output logic [WIDTH-1:0] shifted_o
);

  logic tail;

  always_comb begin
    tail      = seq_tail(mode_i, state_i[WIDTH-1], state_i[WIDTH-2]);
    shifted_o = {state_i[WIDTH-2:0], tail};
  end

endmodule

// File: rtl/seq_classify.sv
module seq_classify import seq_pkg::*; #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic [WIDTH-1:0] state_i,
  input  seq_mode_e        mode_i,
  output logic             legal_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam int unsigned SEQ_MAX = 2 * WIDTH;
  localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

  int unsigned      len;
  logic [WIDTH-1:0] walk;

  // walk the cycle from the seed and match against the held state
  always_comb begin
    len     = seq_len(mode_i, WIDTH);
    walk    = SEED;
    legal_o = 1'b0;
    idx_o   = '0;
    for (int unsigned k = 0; k < SEQ_MAX; k++) begin
      if (k < len && !legal_o && walk == state_i) begin
        legal_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
      walk = {walk[WIDTH-2:0], seq_tail(mode_i, walk[WIDTH-1], walk[WIDTH-2])};
    end
  end

endmodule

// File: rtl/seq_decode.sv
module seq_decode #(
  parameter int unsigned LINES = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             legal_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [LINES-1:0] onehot_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign onehot_o[g] = legal_i && (idx_i == IDX_W'(g));
  end

endmodule

// File: rtl/seq_twisted_ring.sv
module seq_twisted_ring import seq_pkg::*; #(
  parameter int unsigned WIDTH = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_ni,
  input  logic [1:0]           mode_i,
  output logic [WIDTH-1:0]     state_o,
  output logic [2*WIDTH-1:0]   onehot_o,
  output logic                 valid_o
);

  localparam int unsigned SEQ_MAX = 2 * WIDTH;
  localparam int unsigned IDX_W   = $clog2(SEQ_MAX);
  localparam logic [WIDTH-1:0] SEED = WIDTH'(1);

  seq_mode_e        mode;
  logic [WIDTH-1:0] state_q, state_d, shifted;
  logic             legal;
  logic [IDX_W-1:0] idx;

  assign mode = seq_mode_e'(mode_i);

  seq_feedback #(.WIDTH(WIDTH)) u_fb (
    .state_i   (state_q),
    .mode_i    (mode),
    .shifted_o (shifted)
  );

  seq_classify #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_cls (
    .state_i (state_q),
    .mode_i  (mode),
    .legal_o (legal),
    .idx_o   (idx)
  );

  seq_decode #(.LINES(SEQ_MAX), .IDX_W(IDX_W)) u_dec (
    .legal_i  (legal),
    .idx_i    (idx),
    .onehot_o (onehot_o)
  );

  always_comb begin
    if (!clr_ni || !legal) state_d = SEED;
    else                   state_d = shifted;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign valid_o = legal;

  AST_CLR_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> state_o == SEED); // R1
  AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && valid_o) |=> state_o[WIDTH-1:1] == $past(state_o[WIDTH-2:0])); // R2
  AST_RING_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && mode_i == 2'd0) |=> $onehot(state_o)); // R3
  AST_ODD_NO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |=> state_o != '0); // R5
  AST_EVEN_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> (state_o != '0 && state_o != '1)); // R6
  AST_ILLEGAL_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> state_o == SEED); // R7
  AST_DEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot(onehot_o)); // R8
  AST_DEC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> onehot_o == '0); // R8

endmodule

// File: tb/seq_twisted_ring_test.sv
module seq_twisted_ring_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_ni = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic [3:0] state_o;
  logic [7:0] onehot_o;
  logic       valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  seq_twisted_ring uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (clr_ni),
    .mode_i   (mode_i),
    .state_o  (state_o),
    .onehot_o (onehot_o),
    .valid_o  (valid_o)
  );

  // {clr_n, mode, state after edge, valid, position}
  localparam int NV = 41;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1,2'd0,4'b0010,1'b1,3'd1}, // R3
    {1'b1,2'd0,4'b0100,1'b1,3'd2},
    {1'b1,2'd0,4'b1000,1'b1,3'd3},
    {1'b1,2'd0,4'b0001,1'b1,3'd0},
    {1'b1,2'd1,4'b0011,1'b1,3'd1}, // R4
    {1'b1,2'd1,4'b0111,1'b1,3'd2},
    {1'b1,2'd1,4'b1111,1'b1,3'd3},
    {1'b1,2'd1,4'b1110,1'b1,3'd4},
    {1'b1,2'd1,4'b1100,1'b1,3'd5},
    {1'b1,2'd1,4'b1000,1'b1,3'd6},
    {1'b1,2'd1,4'b0000,1'b1,3'd7},
    {1'b1,2'd1,4'b0001,1'b1,3'd0},
    {1'b1,2'd2,4'b0011,1'b1,3'd1}, // R5
    {1'b1,2'd2,4'b0111,1'b1,3'd2},
    {1'b1,2'd2,4'b1111,1'b1,3'd3},
    {1'b1,2'd2,4'b1110,1'b1,3'd4},
    {1'b1,2'd2,4'b1100,1'b1,3'd5},
    {1'b1,2'd2,4'b1000,1'b1,3'd6},
    {1'b1,2'd2,4'b0001,1'b1,3'd0},
    {1'b1,2'd3,4'b0011,1'b1,3'd1}, // R6
    {1'b1,2'd3,4'b0111,1'b1,3'd2},
    {1'b1,2'd3,4'b1110,1'b1,3'd3},
    {1'b1,2'd3,4'b1100,1'b1,3'd4},
    {1'b1,2'd3,4'b1000,1'b1,3'd5},
    {1'b1,2'd3,4'b0001,1'b1,3'd0},
    {1'b1,2'd3,4'b0011,1'b1,3'd1},
    {1'b0,2'd3,4'b0001,1'b1,3'd0}, // R1
    {1'b1,2'd3,4'b0011,1'b1,3'd1},
    {1'b1,2'd1,4'b0111,1'b1,3'd2}, // R9
    {1'b1,2'd1,4'b1111,1'b1,3'd3},
    {1'b1,2'd3,4'b0001,1'b1,3'd0}, // R7 1111 foreign to even
    {1'b1,2'd1,4'b0011,1'b1,3'd1},
    {1'b1,2'd0,4'b0001,1'b1,3'd0}, // R7 0011 foreign to ring
    {1'b1,2'd1,4'b0011,1'b1,3'd1},
    {1'b1,2'd1,4'b0111,1'b1,3'd2},
    {1'b1,2'd1,4'b1111,1'b1,3'd3},
    {1'b1,2'd1,4'b1110,1'b1,3'd4},
    {1'b1,2'd1,4'b1100,1'b1,3'd5},
    {1'b1,2'd1,4'b1000,1'b1,3'd6},
    {1'b1,2'd1,4'b0000,1'b1,3'd7},
    {1'b1,2'd2,4'b0001,1'b1,3'd0}  // R7 0000 foreign to odd
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check("R10 reset state", 32'(state_o), 32'h1);
    check("R8 reset decode", 32'(onehot_o), 32'h01);
    check("R8 reset valid", 32'(valid_o), 32'h1);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      clr_ni = v[10];
      mode_i = v[9:8];
      @(posedge clk_i);
      @(negedge clk_i);
      check($sformatf("R2 step %0d state", i), 32'(state_o), 32'(v[7:4]));
      check($sformatf("R7 step %0d valid", i), 32'(valid_o), 32'(v[3]));
      check($sformatf("R8 step %0d decode", i), 32'(onehot_o),
            v[3] ? (32'h1 << v[2:0]) : 32'h0);
    end

    // R7/R8: foreign state seen before the edge
    mode_i = 2'd1;
    repeat (3) @(negedge clk_i);
    check("R4 climb to full", 32'(state_o), 32'hF);
    mode_i = 2'd3;
    #2;
    check("R7 foreign flag", 32'(valid_o), 32'h0);
    check("R8 foreign decode", 32'(onehot_o), 32'h0);
    @(negedge clk_i);
    check("R7 recovered", 32'(state_o), 32'h1);
    check("R7 recovered valid", 32'(valid_o), 32'h1);

    // R10: asynchronous reset between edges
    mode_i = 2'd1;
    @(negedge clk_i);
    check("R4 before reset", 32'(state_o), 32'h3);
    rst_ni = 1'b0;
    #2;
    check("R10 async seed", 32'(state_o), 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 restart", 32'(state_o), 32'h3);

    summary();
  end

endmodule